// File: doc/BRIEF.md
# Preset Modulus Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It divides the VCO clock by a ratio chosen by a 2-bit mode input. A 4-bit up-counter runs on the VCO clock. On the step that would carry it to its all-ones terminal value of 15, it loads a mode-dependent preset instead. A preset of 10 gives division by 5, and a preset of 4 gives division by 11.

The same mode input picks the reference that the phase detector compares against the divided clock: either the full-rate reference f or the reference f/6. A second output passes one of the two references straight on to the outside. When the loop is locked, the VCO therefore runs at 5f, 5f/6 or 11f/6. The analog loop filter and the VCO itself are not part of this block.

A mode change is held back until the next reload, so the divided output never shows a shortened cycle. The divided output can be built in one of two forms, chosen by a parameter: a near-square wave, or a one-cycle pulse once per period.

Top module: `preset_mod_divider`

## Requirements
- R1: The counter advances by one on every VCO cycle. When the advanced value would be 15, the counter loads the active preset instead, so it never holds 15.
- R2: Mode 2'b10 uses preset 4, which gives a period of 11 VCO cycles between falls of the divided output. Modes 2'b00, 2'b01 and 2'b11 use preset 10, which gives a period of 5.
- R3: The phase detector reference `pdRef` follows `refFull` in mode 2'b00 and follows `refSixth` in modes 2'b01, 2'b10 and 2'b11.
- R4: The pass-through output `passRef` follows `refSixth` in mode 2'b11 and follows `refFull` in every other mode.
- R5: With PULSE_OUT=0, `fbOut` is high for ratio-floor(ratio/2) cycles of each period (3 for ratio 5, 6 for ratio 11) and falls on the cycle the counter reloads.
- R6: With PULSE_OUT=1, `fbOut` is high for exactly one cycle per period: the cycle in which the counter holds 14 and is about to reload.
- R7: A new `modeSel` value takes effect only at the next reload. This applies both to the ratio and to the reference steering, so the period in progress completes at the old ratio.
- R8: While `rst` is high on a clock edge, the counter loads the preset of the current `modeSel`, that mode becomes active at once, and `fbOut` is low. After release, the square output stays low for floor(ratio/2) cycles before it rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO clock |
| rst | input | 1 | Synchronous reset, active high |
| refFull | input | 1 | Reference at f |
| refSixth | input | 1 | Reference at f/6 |
| modeSel | input | 2 | Mode: 00 5f, 01 5f/6, 10 11f/6, 11 difference |
| fbOut | output | 1 | Divided VCO clock to the phase detector |
| pdRef | output | 1 | Reference selected for the phase detector |
| passRef | output | 1 | Pass-through reference output |

## Verification
A wrong count or a wrong preset changes the fall-to-fall interval of `fbOut`, and this shows within one period, at most 11 VCO cycles. A wrong threshold in square mode shows as a wrong high time in the same period. A stale or early active mode shows in two places: immediately as a wrong source on `pdRef` or `passRef`, and as a period of the wrong length across a mode change. After reset, a wrong preset shows as a wrong number of low cycles before the first rising edge.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  parameter int unsigned PMD_CNT_W = 4;

  typedef enum logic [1:0] {
    MODE_5F   = 2'b00,
    MODE_5F6  = 2'b01,
    MODE_SUM  = 2'b10,
    MODE_DIFF = 2'b11
  } pmd_mode_e;

  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic                 clear;
    logic                 load;
    logic [PMD_CNT_W-1:0] preset;
    logic [PMD_CNT_W-1:0] highFrom;
  } pmd_strobe_t;

endpackage

// File: rtl/pmd_ctrl.sv
module pmd_ctrl
  import pmd_pkg::*;
#(
  parameter int unsigned RATIO_LOW  = 5,
  parameter int unsigned RATIO_HIGH = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           modeSel,
  input  logic [PMD_CNT_W-1:0] count,
  output pmd_mode_e            activeMode,
  output pmd_strobe_t          strobe
);

  localparam int unsigned CNT_W    = PMD_CNT_W;
  localparam int unsigned TERM_INT = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] LAST_VAL       = CNT_W'(TERM_INT - 1);
  localparam logic [CNT_W-1:0] PRESET_LOW     = CNT_W'(TERM_INT - RATIO_LOW);
  localparam logic [CNT_W-1:0] PRESET_HIGH    = CNT_W'(TERM_INT - RATIO_HIGH);
  localparam logic [CNT_W-1:0] HIGH_FROM_LOW  = CNT_W'(TERM_INT - RATIO_LOW + RATIO_LOW / 2);
  localparam logic [CNT_W-1:0] HIGH_FROM_HIGH = CNT_W'(TERM_INT - RATIO_HIGH + RATIO_HIGH / 2);

  logic      reloadNow;
  pmd_mode_e requested;
  pmd_mode_e nextMode;

  assign requested = pmd_mode_e'(modeSel);
  // advancing from LAST_VAL would reach the terminal value
  assign reloadNow = (count == LAST_VAL);

  always_comb begin
    if (rst || reloadNow) nextMode = requested;
    else                  nextMode = activeMode;
  end

  always_ff @(posedge clk) begin
    activeMode <= nextMode;
  end

  always_comb begin
    strobe.clear = rst;
    strobe.load  = reloadNow;
    if (nextMode == MODE_SUM) begin
      strobe.preset   = PRESET_HIGH;
      strobe.highFrom = HIGH_FROM_HIGH;
    end else begin
      strobe.preset   = PRESET_LOW;
      strobe.highFrom = HIGH_FROM_LOW;
    end
  end

  AST_RELOAD_PRESET: assert property (@(posedge clk) disable iff (rst)
    (count == LAST_VAL) |=>
      (count == ((activeMode == MODE_SUM) ? PRESET_HIGH : PRESET_LOW))); // R2

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count != LAST_VAL) |=> $stable(activeMode)); // R7

  AST_RESET_PRESET: assert property (@(posedge clk)
    rst |=> (count == ((activeMode == MODE_SUM) ? PRESET_HIGH : PRESET_LOW))); // R8

endmodule

// File: rtl/pmd_dp.sv
module pmd_dp
  import pmd_pkg::*;
#(
  parameter bit PULSE_OUT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pmd_strobe_t          strobe,
  output logic [PMD_CNT_W-1:0] count,
  output logic                 fbOut
);

  localparam int unsigned CNT_W = PMD_CNT_W;
  localparam logic [CNT_W-1:0] TERM_VAL = '1;
  localparam logic [CNT_W-1:0] LAST_VAL = TERM_VAL - 1'b1;

  logic [CNT_W-1:0] nextCount;
  logic             outNext;

  always_comb begin
    if (strobe.clear || strobe.load) nextCount = strobe.preset;
    else                             nextCount = count + 1'b1;
  end

  // output is registered from the next count so it lines up with count
  assign outNext = PULSE_OUT ? (nextCount == LAST_VAL)
                             : (nextCount >= strobe.highFrom);

  always_ff @(posedge clk) begin
    count <= nextCount;
    fbOut <= outNext;
  end

  AST_NO_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    count != TERM_VAL); // R1

  AST_OUT_LOW_IN_RESET: assert property (@(posedge clk)
    rst |=> !fbOut); // R8

  generate
    if (PULSE_OUT) begin : g_pulseChk
      AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fbOut |=> !fbOut); // R6
      AST_PULSE_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
        strobe.load |-> fbOut); // R6
    end else begin : g_squareChk
      AST_SQ_FALL_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        strobe.load |=> !fbOut); // R5
    end
  endgenerate

endmodule

// File: rtl/pmd_steer.sv
module pmd_steer
  import pmd_pkg::*;
(
  input  pmd_mode_e activeMode,
  input  logic      refFull,
  input  logic      refSixth,
  output logic      pdRef,
  output logic      passRef
);

  always_comb begin
    unique case (activeMode)
      MODE_5F:   begin pdRef = refFull;  passRef = refFull;  end
      MODE_5F6:  begin pdRef = refSixth; passRef = refFull;  end
      MODE_SUM:  begin pdRef = refSixth; passRef = refFull;  end
      MODE_DIFF: begin pdRef = refSixth; passRef = refSixth; end
      default:   begin pdRef = refFull;  passRef = refFull;  end
    endcase
  end

endmodule

// File: rtl/preset_mod_divider.sv
module preset_mod_divider
  import pmd_pkg::*;
#(
  parameter int unsigned RATIO_LOW  = 5,
  parameter int unsigned RATIO_HIGH = 11,
  parameter bit          PULSE_OUT  = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refFull,
  input  logic       refSixth,
  input  logic [1:0] modeSel,
  output logic       fbOut,
  output logic       pdRef,
  output logic       passRef
);

  logic [PMD_CNT_W-1:0] count;
  pmd_mode_e            activeMode;
  pmd_strobe_t          strobe;

  pmd_ctrl #(
    .RATIO_LOW (RATIO_LOW),
    .RATIO_HIGH(RATIO_HIGH)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .modeSel   (modeSel),
    .count     (count),
    .activeMode(activeMode),
    .strobe    (strobe)
  );

  pmd_dp #(
    .PULSE_OUT(PULSE_OUT)
  ) dp_i (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .count (count),
    .fbOut (fbOut)
  );

  pmd_steer steer_i (
    .activeMode(activeMode),
    .refFull   (refFull),
    .refSixth  (refSixth),
    .pdRef     (pdRef),
    .passRef   (passRef)
  );

endmodule

// File: tb/preset_mod_divider_tb_top.sv
module preset_mod_divider_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       refFull = 1'b0;
  logic       refSixth = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       sqOut, pdRef, passRef;
  logic       plsOut, pdRefP, passRefP;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  preset_mod_divider #(.PULSE_OUT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .refFull(refFull), .refSixth(refSixth),
    .modeSel(modeSel), .fbOut(sqOut), .pdRef(pdRef), .passRef(passRef)
  );

  preset_mod_divider #(.PULSE_OUT(1'b1)) dutPulse_i (
    .clk(clk), .rst(rst), .refFull(refFull), .refSixth(refSixth),
    .modeSel(modeSel), .fbOut(plsOut), .pdRef(pdRefP), .passRef(passRefP)
  );

  function automatic int expRatio(int m);
    return (m == 2) ? 11 : 5;
  endfunction

  function automatic int expPd(int m, int f, int s);
    return (m == 0) ? f : s;
  endfunction

  function automatic int expPass(int m, int f, int s);
    return (m == 3) ? s : f;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // samples at falling clock edges until the chosen output falls
  task automatic nextFall(input bit usePulse, output int per, output int hi);
    logic prev;
    logic cur;
    per  = 0;
    hi   = 0;
    prev = usePulse ? plsOut : sqOut;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      cur = usePulse ? plsOut : sqOut;
      per++;
      if (cur) hi++;
      if (prev && !cur) break;
      prev = cur;
    end
  endtask

  task automatic doReset(int m);
    int lows;
    @(negedge clk);
    modeSel = 2'(m);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8", "square low in reset", int'(sqOut), 0);
    check("R8", "pulse low in reset", int'(plsOut), 0);
    rst = 1'b0;
    lows = 0;
    while (!sqOut && lows < 64) begin
      lows++;
      @(negedge clk);
    end
    check("R8", "low cycles after release", lows, expRatio(m) / 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi;
    for (int m = 0; m < 4; m++) begin
      doReset(m);
      nextFall(1'b0, per, hi);
      nextFall(1'b0, per, hi);
      check("R1 R2", "square period", per, expRatio(m));
      check("R5", "square high time", hi, expRatio(m) - expRatio(m) / 2);
      nextFall(1'b1, per, hi);
      nextFall(1'b1, per, hi);
      check("R6", "pulse period", per, expRatio(m));
      check("R6", "pulse high time", hi, 1);
      for (int f = 0; f < 2; f++) begin
        for (int s = 0; s < 2; s++) begin
          refFull  = 1'(f);
          refSixth = 1'(s);
          #1;
          check("R3", "pdRef", int'(pdRef), expPd(m, f, s));
          check("R4", "passRef", int'(passRef), expPass(m, f, s));
        end
      end
    end

    // mode change mid-period: 5f -> sum
    doReset(0);
    nextFall(1'b0, per, hi);
    refFull  = 1'b1;
    refSixth = 1'b0;
    modeSel  = 2'b10;
    #1;
    check("R7", "pdRef before reload", int'(pdRef), 1);
    nextFall(1'b0, per, hi);
    check("R7", "period in progress keeps old ratio", per, 5);
    #1;
    check("R7", "pdRef after reload", int'(pdRef), 0);
    nextFall(1'b0, per, hi);
    check("R7", "new ratio period", per, 11);
    check("R5", "new ratio high time", hi, 6);

    // sum -> difference, changed a few cycles into the period
    @(negedge clk);
    @(negedge clk);
    modeSel = 2'b11;
    refFull  = 1'b0;
    refSixth = 1'b1;
    #1;
    check("R7", "passRef before reload", int'(passRef), 0);
    nextFall(1'b0, per, hi);
    check("R7", "remaining sum period", per, 9);
    #1;
    check("R7", "passRef after reload", int'(passRef), 1);
    nextFall(1'b0, per, hi);
    check("R7", "difference mode period", per, 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule